// File: doc/BRIEF.md
# Manchester II Word Encoder

This block turns a 16-bit word into one Manchester II bipolar frame of 20 bit periods: three bit times of sync, sixteen data bits sent most significant bit first, then an odd parity bit. The sync shape tells the receiver whether the word is a command or data. The encoder does not take the word in parallel. It raises a send-data request for sixteen bit periods and samples one serial bit on each rising edge of its shift clock during that window.

All logic runs in one clock domain and is driven by clock enables. An encoder-tick enable is divided by a parameter (six by default, or bypassed when the parameter is 1) to give the send tick. The send tick marks half-bit steps. A shift clock at the bit rate is derived from it. The shift clock falls at each bit boundary and rises at mid-bit. Two complementary lines, bipolar-one and bipolar-zero, carry the frame. An active-low inhibit forces both lines high. A master reset input aborts a frame on the next send tick.

The sequencer has four states. IDLE moves to SYNC when enable is high at a bit boundary. SYNC moves to DATA after its third bit. DATA moves to PARITY after the sixteenth data bit. PARITY moves to SYNC if enable is still high, which gives back-to-back words, and to IDLE otherwise. An abort sends any state to IDLE.

Top module: `mch_word_enc`

## Requirements
- R1: One send tick occurs per DIV encoder ticks (DIV=6 by default). The shift clock changes only on a send tick, falling at each bit boundary and rising at mid-bit.
- R2: A frame starts at the first bit boundary at which enable is high. The sync select level at that same boundary fixes the sync type. A frame lasts 20 bit periods.
- R3: A command sync (sync select high) drives bipolar-one high for three half-bits and then low for three half-bits. A data sync is the inverse.
- R4: Data bits go out in frame bits 3 to 18, bit 15 first. A logic 1 is high on bipolar-one in the first half of the bit and low in the second half; a logic 0 is the reverse.
- R5: Send-data is high for exactly 16 bit periods, frame bits 2 to 17. The serial input is sampled at the mid-bit rising shift-clock edge of each window bit, and that bit is transmitted in the following bit period.
- R6: Frame bit 19 carries parity chosen so that the 16 data bits plus parity hold an odd number of ones, Manchester coded like a data bit.
- R7: If enable is high at the boundary that ends bit 19, the next frame's sync starts at once with no gap. If enable is low there, the encoder returns to idle.
- R8: While idle and not inhibited, both lines are low. During a frame and not inhibited, bipolar-zero is the complement of bipolar-one.
- R9: While inhibit_n is low, both lines are high. The frame timing, data and parity are unaffected.
- R10: A master reset pulse aborts the frame at the first send tick during or after the pulse. Until that tick the frame continues. After it the encoder is idle and accepts a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| enc_tick | input | 1 | Encoder clock enable, divided to form the send tick |
| mreset | input | 1 | Master reset: abort request, acted on at the next send tick |
| enable | input | 1 | Start a word, or continue with a back-to-back word |
| sync_sel | input | 1 | 1 = command sync, 0 = data sync |
| sdi | input | 1 | Serial data input, MSB first |
| inhibit_n | input | 1 | Active-low output inhibit |
| send_tick_o | output | 1 | Divided send tick, one per half-bit |
| shift_clk_o | output | 1 | Bit-rate shift clock |
| send_data_o | output | 1 | Serial data request window |
| bip_one_o | output | 1 | Bipolar-one line |
| bip_zero_o | output | 1 | Bipolar-zero line |

## Verification
The hardest case to reach from the ports is the changeover from PARITY straight into SYNC for a new word. Here enable must still be high at one exact boundary, and the next word's sync type must already be on sync select. The bench keeps enable high through chained vectors and loads the next sync select halfway through each frame. The serial input is fed from the send-data window. Each half-bit of both lines is captured for decoding. The abort case pulses master reset between two send ticks. This shows that the frame runs on until the tick and only then falls idle.

// File: rtl/mch_pkg.sv
package mch_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_SYNC,
        S_DATA,
        S_PAR
    } mch_state_e;

    localparam int SYNC_BITS = 3;
endpackage

// File: rtl/mch_prescale.sv
module mch_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_tick,
    output logic send_tick
);
    generate
        if (DIV > 1) begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (enc_tick) begin
                    if (cnt == CW'(DIV - 1)) cnt <= '0;
                    else                     cnt <= cnt + 1'b1;
                end
            end

            assign send_tick = enc_tick && (cnt == CW'(DIV - 1));
        end else begin : g_bypass
            assign send_tick = enc_tick;
        end
    endgenerate
endmodule

// File: rtl/mch_seq.sv
module mch_seq
    import mch_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int FRAME_BITS = SYNC_BITS + DATA_W + 1,
    localparam int IDX_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send_tick,
    input  logic             mreset,
    input  logic             enable,
    input  logic             sync_sel,
    input  logic             sdi,
    output mch_state_e       state,
    output logic             phase,
    output logic [IDX_W-1:0] bit_idx,
    output logic             cmd_sync,
    output logic             cur_bit,
    output logic             par_bit,
    output logic             send_data
);
    localparam int WIN_FIRST = SYNC_BITS - 1;
    localparam int WIN_LAST  = SYNC_BITS + DATA_W - 2;
    localparam int LAST_DATA = SYNC_BITS + DATA_W - 1;

    logic nxt_bit;
    logic par_acc;
    logic abort_pend;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            phase      <= 1'b0;
            bit_idx    <= '0;
            cmd_sync   <= 1'b0;
            cur_bit    <= 1'b0;
            nxt_bit    <= 1'b0;
            par_acc    <= 1'b0;
            abort_pend <= 1'b0;
        end else if (send_tick && (mreset || abort_pend)) begin
            state      <= S_IDLE;
            phase      <= 1'b0;
            bit_idx    <= '0;
            abort_pend <= 1'b0;
        end else begin
            if (mreset) abort_pend <= 1'b1;
            if (send_tick && !phase) begin
                // mid-bit: shift clock rises, serial bit sampled
                phase <= 1'b1;
                if (send_data) nxt_bit <= sdi;
            end else if (send_tick && phase) begin
                // bit boundary: shift clock falls
                phase <= 1'b0;
                unique case (state)
                    S_IDLE: begin
                        if (enable) begin
                            state    <= S_SYNC;
                            bit_idx  <= '0;
                            cmd_sync <= sync_sel;
                            par_acc  <= 1'b0;
                        end
                    end
                    S_SYNC: begin
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == IDX_W'(SYNC_BITS - 1)) begin
                            state   <= S_DATA;
                            cur_bit <= nxt_bit;
                            par_acc <= par_acc ^ nxt_bit;
                        end
                    end
                    S_DATA: begin
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == IDX_W'(LAST_DATA)) begin
                            state <= S_PAR;
                        end else begin
                            cur_bit <= nxt_bit;
                            par_acc <= par_acc ^ nxt_bit;
                        end
                    end
                    S_PAR: begin
                        bit_idx <= '0;
                        if (enable) begin
                            state    <= S_SYNC;
                            cmd_sync <= sync_sel;
                            par_acc  <= 1'b0;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // output process
    always_comb begin
        par_bit = ~par_acc;
        unique case (state)
            S_SYNC:  send_data = (bit_idx == IDX_W'(WIN_FIRST));
            S_DATA:  send_data = (bit_idx <= IDX_W'(WIN_LAST));
            default: send_data = 1'b0;
        endcase
    end
endmodule

// File: rtl/mch_linecode.sv
module mch_linecode
    import mch_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  mch_state_e       state,
    input  logic             phase,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmd_sync,
    input  logic             cur_bit,
    input  logic             par_bit,
    input  logic             inhibit_n,
    output logic             bip_one,
    output logic             bip_zero
);
    logic sync_hi;
    logic lvl;

    always_comb begin
        // first three half-bits of the sync field
        sync_hi = (bit_idx == '0) || ((bit_idx == IDX_W'(1)) && !phase);
        lvl     = 1'b0;
        unique case (state)
            S_SYNC:  lvl = cmd_sync ? sync_hi : ~sync_hi;
            S_DATA:  lvl = cur_bit ^ phase;
            S_PAR:   lvl = par_bit ^ phase;
            default: lvl = 1'b0;
        endcase
        if (!inhibit_n) begin
            bip_one  = 1'b1;
            bip_zero = 1'b1;
        end else if (state == S_IDLE) begin
            bip_one  = 1'b0;
            bip_zero = 1'b0;
        end else begin
            bip_one  = lvl;
            bip_zero = ~lvl;
        end
    end
endmodule

// File: rtl/mch_word_enc.sv
module mch_word_enc
    import mch_pkg::*;
#(
    parameter int DIV    = 6,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_tick,
    input  logic mreset,
    input  logic enable,
    input  logic sync_sel,
    input  logic sdi,
    input  logic inhibit_n,
    output logic send_tick_o,
    output logic shift_clk_o,
    output logic send_data_o,
    output logic bip_one_o,
    output logic bip_zero_o
);
    localparam int FRAME_BITS = SYNC_BITS + DATA_W + 1;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    logic             send_tick;
    mch_state_e       state;
    logic             phase;
    logic [IDX_W-1:0] bit_idx;
    logic             cmd_sync;
    logic             cur_bit;
    logic             par_bit;
    logic             send_data;

    mch_prescale #(.DIV(DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .enc_tick  (enc_tick),
        .send_tick (send_tick)
    );

    mch_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .send_tick (send_tick),
        .mreset    (mreset),
        .enable    (enable),
        .sync_sel  (sync_sel),
        .sdi       (sdi),
        .state     (state),
        .phase     (phase),
        .bit_idx   (bit_idx),
        .cmd_sync  (cmd_sync),
        .cur_bit   (cur_bit),
        .par_bit   (par_bit),
        .send_data (send_data)
    );

    mch_linecode #(.IDX_W(IDX_W)) u_line (
        .state     (state),
        .phase     (phase),
        .bit_idx   (bit_idx),
        .cmd_sync  (cmd_sync),
        .cur_bit   (cur_bit),
        .par_bit   (par_bit),
        .inhibit_n (inhibit_n),
        .bip_one   (bip_one_o),
        .bip_zero  (bip_zero_o)
    );

    assign send_tick_o = send_tick;
    assign shift_clk_o = phase;
    assign send_data_o = send_data;
endmodule

// File: rtl/mch_checker.sv
module mch_checker
    import mch_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mreset,
    input logic       inhibit_n,
    input logic       send_tick_o,
    input logic       shift_clk_o,
    input logic       send_data_o,
    input logic       bip_one_o,
    input logic       bip_zero_o,
    input mch_state_e state
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pend_q <= 1'b0;
        else if (send_tick_o) pend_q <= 1'b0;
        else if (mreset)      pend_q <= 1'b1;
    end

    AST_SHCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !send_tick_o |=> $stable(shift_clk_o)); // R1
    AST_WINDOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        send_data_o |-> (state == S_SYNC || state == S_DATA)); // R5
    AST_LINES_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && state != S_IDLE) |-> (bip_one_o != bip_zero_o)); // R8
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && state == S_IDLE) |-> (!bip_one_o && !bip_zero_o)); // R8
    AST_INHIBIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |-> (bip_one_o && bip_zero_o)); // R9
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (send_tick_o && (mreset || pend_q)) |=> (state == S_IDLE)); // R10
endmodule

bind mch_word_enc mch_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mreset      (mreset),
    .inhibit_n   (inhibit_n),
    .send_tick_o (send_tick_o),
    .shift_clk_o (shift_clk_o),
    .send_data_o (send_data_o),
    .bip_one_o   (bip_one_o),
    .bip_zero_o  (bip_zero_o),
    .state       (state)
);

// File: tb/sim_mch_word_enc.sv
`timescale 1ns/1ps
module sim_mch_word_enc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_tick = 1'b1;
    logic mreset = 1'b0;
    logic enable = 1'b0;
    logic sync_sel = 1'b0;
    logic sdi = 1'b0;
    logic inhibit_n = 1'b1;
    logic send_tick_o, shift_clk_o, send_data_o, bip_one_o, bip_zero_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    mch_word_enc u0 (
        .clk(clk), .rst_n(rst_n), .enc_tick(enc_tick), .mreset(mreset),
        .enable(enable), .sync_sel(sync_sel), .sdi(sdi), .inhibit_n(inhibit_n),
        .send_tick_o(send_tick_o), .shift_clk_o(shift_clk_o),
        .send_data_o(send_data_o), .bip_one_o(bip_one_o), .bip_zero_o(bip_zero_o)
    );

    // fields: data[18:3], cmd[2], stay[1], inhibit[0]
    localparam logic [18:0] VEC [0:5] = '{
        {16'hA5C3, 1'b1, 1'b0, 1'b0},
        {16'h0000, 1'b0, 1'b0, 1'b1},
        {16'hFFFF, 1'b1, 1'b1, 1'b0},
        {16'h1234, 1'b0, 1'b1, 1'b0},
        {16'h8001, 1'b1, 1'b0, 1'b0},
        {16'h7FFE, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic align_start(input bit cmd);
        @(posedge shift_clk_o);
        @(negedge clk);
        enable   = 1'b1;
        sync_sel = cmd;
    endtask

    task automatic frame(input logic [15:0] d, input bit cmd, input bit stay,
                         input bit nxt_cmd, input bit inh);
        logic [39:0] one_s, zero_s;
        logic [15:0] got, mask;
        int win = 0;
        int k = 0;
        int bad_man = 0;
        int bad_line = 0;
        logic [5:0] exp_sync;
        for (int h = 0; h < 40; h++) begin
            if (h % 2 == 0) @(negedge shift_clk_o);
            else            @(posedge shift_clk_o);
            @(negedge clk);
            @(negedge clk);
            one_s[h]  = bip_one_o;
            zero_s[h] = bip_zero_o;
            if (send_data_o) win++;
            if ((h % 2 == 0) && send_data_o && k < 16) begin
                sdi = d[15-k];
                k++;
            end
            if (h == 0)  enable = stay;
            if (h == 20) sync_sel = nxt_cmd;
            if (inh && h == 9)  inhibit_n = 1'b0;
            if (inh && h == 13) inhibit_n = 1'b1;
        end
        exp_sync = cmd ? 6'b000111 : 6'b111000;
        chk(one_s[5:0] == exp_sync, "R3 sync shape", {26'd0, one_s[5:0]}, {26'd0, exp_sync});
        mask = inh ? ~16'h3000 : 16'hFFFF;
        for (int b = 0; b < 16; b++) begin
            got[15-b] = one_s[6+2*b];
            if (mask[15-b] && (one_s[7+2*b] == one_s[6+2*b])) bad_man++;
        end
        chk(((got & mask) == (d & mask)) && bad_man == 0, "R4 data decode",
            {16'd0, got & mask}, {16'd0, d & mask});
        chk(one_s[38] == ~^d && one_s[39] == ^d, "R6 parity bit",
            {30'd0, one_s[38], one_s[39]}, {30'd0, ~^d, ^d});
        for (int h = 0; h < 40; h++) begin
            if (inh && h >= 10 && h <= 13) begin
                if (!(one_s[h] && zero_s[h])) bad_line++;
            end else if (zero_s[h] != ~one_s[h]) begin
                bad_line++;
            end
        end
        chk(bad_line == 0, inh ? "R9 inhibit high, R8 complement" : "R8 complement",
            bad_line, 0);
        chk(win == 32, "R5 window length (half-bits)", win, 32);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog act=running exp=done");
        summary();
    end

    initial begin
        int n;
        bit prev_stay;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!bip_one_o && !bip_zero_o && !send_data_o && !shift_clk_o, "R8 reset idle",
            {bip_one_o, bip_zero_o, send_data_o, shift_clk_o}, 0);

        // R1: shift clock half period equals DIV encoder ticks
        @(posedge shift_clk_o);
        @(negedge clk);
        n = 0;
        while (shift_clk_o) begin
            @(negedge clk);
            n++;
        end
        chk(n == 6, "R1 half-bit length in clocks", n, 6);

        // vector table
        prev_stay = 1'b0;
        for (int i = 0; i < 6; i++) begin
            logic [18:0] v;
            bit nc;
            v  = VEC[i];
            nc = (i < 5) ? VEC[i+1][2] : 1'b0;
            if (!prev_stay) align_start(v[2]);
            frame(v[18:3], v[2], v[1], nc, v[0]);
            if (!v[1]) begin
                // R2 frame length / R7 return to idle after bit 19
                @(negedge shift_clk_o);
                @(negedge clk);
                @(negedge clk);
                chk(!bip_one_o && !bip_zero_o && !send_data_o, "R7 idle after frame",
                    {bip_one_o, bip_zero_o, send_data_o}, 0);
            end
            prev_stay = v[1];
        end

        // R9: inhibit while idle
        @(negedge clk);
        inhibit_n = 1'b0;
        @(negedge clk);
        chk(bip_one_o && bip_zero_o, "R9 inhibit idle", {bip_one_o, bip_zero_o}, 2'b11);
        inhibit_n = 1'b1;
        @(negedge clk);
        chk(!bip_one_o && !bip_zero_o, "R9 release idle", {bip_one_o, bip_zero_o}, 2'b00);

        // R10: abort in the middle of a frame
        align_start(1'b1);
        sdi = 1'b1;
        @(negedge shift_clk_o);
        @(negedge clk);
        enable = 1'b0;
        @(posedge send_data_o);
        @(negedge clk);
        mreset = 1'b1;
        @(negedge clk);
        mreset = 1'b0;
        chk(send_data_o && (bip_one_o != bip_zero_o), "R10 frame runs until tick",
            {send_data_o, bip_one_o, bip_zero_o}, 3'b1xx);
        repeat (6) @(negedge clk);
        chk(!send_data_o && !bip_one_o && !bip_zero_o, "R10 idle after abort",
            {send_data_o, bip_one_o, bip_zero_o}, 0);

        // R10: new word accepted after abort
        align_start(1'b0);
        frame(16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge shift_clk_o);
        @(negedge clk);
        chk(!bip_one_o && !bip_zero_o, "R10 R2 idle after restart frame",
            {bip_one_o, bip_zero_o}, 0);

        summary();
    end
endmodule